// File: doc/BRIEF.md
# Parallel-Port Control-Line Edge Monitor

This block watches four host-driven control lines of a 1284-style parallel port and records transitions on them in a sticky status register. Each line has its own falling-edge enable and rising-edge enable, so software can pick which direction of change it cares about, or both. A recorded event raises a level interrupt toward the CPU. The interrupt stays up until software clears the status.

Monitoring is live only while the port is in manual mode. Software reaches the registers through a small 8-bit register interface. Reads are strobed and return data one cycle after the strobe. The status register is cleared by writing any value to it, and reading it has no side effects.

Each line passes through a two-flop synchronizer before the edge comparison. Register offsets are: 0 for the falling-edge enables, 1 for the rising-edge enables and 2 for the status. Line bits are mapped as follows: bit 3 is the address-strobe line, bit 2 the initialize line, bit 1 the host-busy line and bit 0 the host-clock line.

Top module: `sigchg_detector`

## Requirements
- R1: After reset, both enable registers and the status register read 0x00, and `irq` is low.
- R2: When bit n of the falling-edge enable register (offset 0) is set, a high-to-low change on `lineIn[n]` sets status bit n.
- R3: When bit n of the rising-edge enable register (offset 1) is set, a low-to-high change on `lineIn[n]` sets status bit n. A line may have both edges enabled.
- R4: A change on a line whose enable for that direction is clear leaves the status unchanged, and a line that does not change sets nothing.
- R5: While `manualMode` is low, no line change sets any status bit.
- R6: A write of any data value to offset 2 clears all status bits. Status bits are otherwise sticky.
- R7: If an enabled edge is recorded in the same cycle as a clearing write, that edge's status bit is set after the write.
- R8: Bits 7:4 of all three registers read as zero, even after 0xFF is written.
- R9: `irq` is high exactly when some status bit is set, `sigIntEn` is high and `manualMode` is high. It stays high until the status is cleared.
- R10: Reading the status register leaves it and `irq` unchanged.
- R11: Because of the synchronizer, a line change driven before clock edge k sets its status bit at edge k+2, and not before.
- R12: `busRdata` is loaded only on a clock edge where `busRe` is high, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| manualMode | input | 1 | Port is in manual mode; edge monitoring active |
| sigIntEn | input | 1 | Global signal-change interrupt enable |
| lineIn | input | 4 | Monitored lines: 3 address strobe, 2 initialize, 1 host busy, 0 host clock |
| busAddr | input | 4 | Register offset |
| busWdata | input | 8 | Write data |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busRdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
Two functions can land in the same cycle: a clearing write to the status register and the recording of an enabled edge. The bench provokes this by driving a line change and counting synchronizer stages, so that the write strobe is high during exactly the cycle in which the edge comparison fires. It then reads the status back and expects the new bit to survive while every older bit is gone. The same edge-counting approach pins down the synchronizer latency: the bench checks that the interrupt is still low one edge early and is high on the expected edge.

// File: rtl/sigchg_pkg.sv
package sigchg_pkg;

  // Register offsets on the register interface
  localparam int unsigned OFS_FALL = 0;
  localparam int unsigned OFS_RISE = 1;
  localparam int unsigned OFS_STAT = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic fallWe;
    logic riseWe;
    logic statClr;
  } regStrobe_t;

endpackage

// File: rtl/sigchg_ctrl.sv
module sigchg_ctrl
  import sigchg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [LINES-1:0]  fallEnQ,
  input  logic [LINES-1:0]  riseEnQ,
  input  logic [LINES-1:0]  statusQ,
  output regStrobe_t        strobes,
  output logic [DATA_W-1:0] busRdata
);

  localparam int PAD_W = DATA_W - LINES;

  logic              selFall, selRise, selStat;
  logic [DATA_W-1:0] rdSel;

  assign selFall = (busAddr == ADDR_W'(OFS_FALL));
  assign selRise = (busAddr == ADDR_W'(OFS_RISE));
  assign selStat = (busAddr == ADDR_W'(OFS_STAT));

  always_comb begin
    strobes.fallWe  = busWe && selFall;
    strobes.riseWe  = busWe && selRise;
    strobes.statClr = busWe && selStat;
  end

  // Read mux: upper bits are zero-padded
  always_comb begin
    rdSel = '0;
    if (selFall)      rdSel = {{PAD_W{1'b0}}, fallEnQ};
    else if (selRise) rdSel = {{PAD_W{1'b0}}, riseEnQ};
    else if (selStat) rdSel = {{PAD_W{1'b0}}, statusQ};
  end

  always_ff @(posedge clk) begin
    if (!rstN)      busRdata <= '0;
    else if (busRe) busRdata <= rdSel;
  end

  // R8: padding bits never appear on the read bus
  p_rd_pad_r8: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[DATA_W-1:LINES] == '0);

  // R12: read data holds without a read strobe
  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !busRe |=> $stable(busRdata));

endmodule

// File: rtl/sigchg_datapath.sv
module sigchg_datapath
  import sigchg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              manualMode,
  input  logic [LINES-1:0]  lineIn,
  input  logic [DATA_W-1:0] busWdata,
  input  regStrobe_t        strobes,
  output logic [LINES-1:0]  fallEnQ,
  output logic [LINES-1:0]  riseEnQ,
  output logic [LINES-1:0]  statusQ
);

  logic [LINES-1:0] syncA, syncB, prevQ;
  logic [LINES-1:0] fallHit, riseHit, events;

  // Per-line synchronizer and previous-sample flop
  for (genvar g = 0; g < LINES; g++) begin : gLine
    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncA[g] <= 1'b0;
        syncB[g] <= 1'b0;
        prevQ[g] <= 1'b0;
      end else begin
        syncA[g] <= lineIn[g];
        syncB[g] <= syncA[g];
        prevQ[g] <= syncB[g];
      end
    end
  end

  assign fallHit = prevQ & ~syncB & fallEnQ;
  assign riseHit = ~prevQ & syncB & riseEnQ;
  assign events  = (fallHit | riseHit) & {LINES{manualMode}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fallEnQ <= '0;
      riseEnQ <= '0;
      statusQ <= '0;
    end else begin
      if (strobes.fallWe) fallEnQ <= busWdata[LINES-1:0];
      if (strobes.riseWe) riseEnQ <= busWdata[LINES-1:0];
      // new events win over a same-cycle clear
      statusQ <= (strobes.statClr ? '0 : statusQ) | events;
    end
  end

  // R6: bits are sticky unless cleared
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.statClr |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  // R5: no new bits outside manual mode
  p_no_manual_r5: assert property (@(posedge clk) disable iff (!rstN)
    !manualMode |=> ((statusQ & ~$past(statusQ)) == '0));

  // R7: a clear with a coincident event leaves exactly that event
  p_event_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.statClr |=> (statusQ == $past(events)));

endmodule

// File: rtl/sigchg_detector.sv
module sigchg_detector
  import sigchg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              manualMode,
  input  logic              sigIntEn,
  input  logic [LINES-1:0]  lineIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWe,
  input  logic              busRe,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);

  regStrobe_t       strobes;
  logic [LINES-1:0] fallEnQ, riseEnQ, statusQ;

  sigchg_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busRe    (busRe),
    .fallEnQ  (fallEnQ),
    .riseEnQ  (riseEnQ),
    .statusQ  (statusQ),
    .strobes  (strobes),
    .busRdata (busRdata)
  );

  sigchg_datapath #(.DATA_W(DATA_W), .LINES(LINES)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .manualMode (manualMode),
    .lineIn     (lineIn),
    .busWdata   (busWdata),
    .strobes    (strobes),
    .fallEnQ    (fallEnQ),
    .riseEnQ    (riseEnQ),
    .statusQ    (statusQ)
  );

  assign irq = (|statusQ) && sigIntEn && manualMode;

  // R9: gating inputs low force the interrupt low
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!sigIntEn || !manualMode) |-> !irq);

  // R9: a raised interrupt persists until a clear or a gate drop
  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !strobes.statClr) |=> (irq || !sigIntEn || !manualMode));

endmodule

// File: tb/sigchg_detector_test.sv
module sigchg_detector_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic       manualMode, sigIntEn;
  logic [3:0] lineIn, busAddr;
  logic [7:0] busWdata, busRdata;
  logic       busWe, busRe, irq;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;  // 250 MHz

  sigchg_detector uut (
    .clk(clk), .rstN(rstN), .manualMode(manualMode), .sigIntEn(sigIntEn),
    .lineIn(lineIn), .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe),
    .busRe(busRe), .busRdata(busRdata), .irq(irq)
  );

  // {fallEn, riseEn, manual, startLines, endLines, expStatus}
  localparam logic [20:0] VEC [8] = '{
    {4'b1111, 4'b0000, 1'b1, 4'b1111, 4'b0000, 4'b1111},  // R2 all falling
    {4'b0000, 4'b1111, 1'b1, 4'b0000, 4'b1111, 4'b1111},  // R3 all rising
    {4'b0101, 4'b0000, 1'b1, 4'b1111, 4'b0000, 4'b0101},  // R2 partial
    {4'b0000, 4'b1010, 1'b1, 4'b0000, 4'b1111, 4'b1010},  // R3 partial
    {4'b1111, 4'b1111, 1'b0, 4'b1111, 4'b0000, 4'b0000},  // R5 not manual
    {4'b1100, 4'b0011, 1'b1, 4'b0101, 4'b1010, 4'b0110},  // R3 mixed dirs
    {4'b0000, 4'b0000, 1'b1, 4'b0000, 4'b1111, 4'b0000},  // R4 disabled
    {4'b1000, 4'b1000, 1'b1, 4'b1000, 4'b1000, 4'b0000}   // R4 no change
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busRe = 1'b0;
    d = busRdata;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] rd, rd2;
    rstN = 1'b0; manualMode = 1'b1; sigIntEn = 1'b1; lineIn = '0;
    busAddr = '0; busWdata = '0; busWe = 1'b0; busRe = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 irq", {7'b0, irq}, 8'h00);
    regRead(4'd0, rd); check("R1 fall", rd, 8'h00);
    regRead(4'd1, rd); check("R1 rise", rd, 8'h00);
    regRead(4'd2, rd); check("R1 stat", rd, 8'h00);

    // Vector loop
    for (int i = 0; i < 8; i++) begin
      logic [3:0] fe, re, st, en, ex;
      logic       mm;
      {fe, re, mm, st, en, ex} = VEC[i];
      regWrite(4'd0, {4'b0, fe});
      regWrite(4'd1, {4'b0, re});
      @(negedge clk);
      manualMode = mm; lineIn = st;
      settle();
      regWrite(4'd2, 8'h00);
      @(negedge clk);
      lineIn = en;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check($sformatf("R2/R3/R4/R5 vec%0d irq", i), {7'b0, irq},
            {7'b0, (ex != 0) && mm});
      regRead(4'd2, rd);
      check($sformatf("R2/R3/R4/R5 vec%0d stat", i), rd, {4'b0, ex});
      @(negedge clk);
      manualMode = 1'b1;
    end

    // R8 padding bits
    regWrite(4'd0, 8'hFF);
    regRead(4'd0, rd); check("R8 fall pad", rd, 8'h0F);
    regWrite(4'd1, 8'hFF);
    regRead(4'd1, rd); check("R8 rise pad", rd, 8'h0F);

    // R12 hold without strobe
    @(negedge clk);
    busAddr = 4'd2;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R12 hold", busRdata, 8'h0F);

    // R11 latency: fall on bit 0 only
    regWrite(4'd1, 8'h00);
    regWrite(4'd0, 8'h01);
    @(negedge clk); lineIn = 4'b0001;
    settle();
    regWrite(4'd2, 8'h00);
    @(negedge clk); lineIn = 4'b0000;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R11 early", {7'b0, irq}, 8'h00);
    @(posedge clk);
    @(negedge clk);
    check("R11 on time", {7'b0, irq}, 8'h01);

    // R10 read has no side effect
    regRead(4'd2, rd);
    regRead(4'd2, rd2);
    check("R10 reread", rd2, 8'h01);
    check("R10 irq", {7'b0, irq}, 8'h01);

    // R9 gating
    @(negedge clk); sigIntEn = 1'b0;
    #1 check("R9 en off", {7'b0, irq}, 8'h00);
    @(negedge clk); sigIntEn = 1'b1;
    #1 check("R9 en on", {7'b0, irq}, 8'h01);
    @(negedge clk); manualMode = 1'b0;
    #1 check("R9 manual off", {7'b0, irq}, 8'h00);
    @(negedge clk); manualMode = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R9 sticky", {7'b0, irq}, 8'h01);

    // R6 clear with arbitrary data
    regWrite(4'd2, 8'hA5);
    check("R6 irq", {7'b0, irq}, 8'h00);
    regRead(4'd2, rd); check("R6 stat", rd, 8'h00);

    // R7 same-cycle clear and event: bit 2 old, bit 0 new
    regWrite(4'd0, 8'h05);
    @(negedge clk); lineIn = 4'b0101;
    settle();
    @(negedge clk); lineIn = 4'b0001;   // fall on bit 2
    settle();
    regRead(4'd2, rd); check("R7 pre", rd, 8'h04);
    @(negedge clk); lineIn = 4'b0000;   // fall on bit 0
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    busAddr = 4'd2; busWdata = 8'h3C; busWe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWe = 1'b0;
    regRead(4'd2, rd); check("R7 event wins", rd, 8'h01);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule